// File: doc/BRIEF.md
# Modem Line Change Detector with Receive Status Register

This block watches four modem control inputs from a serial line adapter. Depending on the electrical mode, the four lines are clear-to-send, carrier detect, data set ready and ring indicator, or clear-to-send, receiver ready, data mode and incoming call. The block does not depend on which set is wired. Each input first passes through a synchronizer. The block then compares consecutive synchronized samples. A rising or falling level on any line whose enable bit is set latches a sticky change flag.

The flag, the current line levels, four per-line enables and two interrupt enables share one 16-bit receive control/status register. The host accesses this register through a simple strobe interface with two byte enables. An interrupt request is raised only while the change flag and both interrupt enables are set. A host read that includes the high byte clears the flag, unless a new change arrives in the same cycle.

The external reset is asynchronous and active low. Its release is synchronized inside the block, which adds two clock cycles before the logic leaves reset.

Top module: `mdm_change_csr`

## Requirements
- R1: After reset the register reads 16'h0000 and `dsc_irq` is low. All line enables (bits 3:0) and both interrupt enables start cleared.
- R2: Each line passes through two flip-flop stages. Line i is readable at register bit 11+i. The new level appears after the second rising clock edge that follows a change at the pin.
- R3: A rising or falling change on line i sets bit 15 when enable bit i (register bit i) is 1. Bit 15 becomes visible after the third rising clock edge that follows the change at the pin.
- R4: A change on a line whose enable bit is 0 leaves bit 15 unchanged. The line's level bit still follows the pin.
- R5: Once set, bit 15 stays set until a clearing read, whatever the lines do afterwards.
- R6: A read strobe with `csr_be[1]` = 1 (high-byte or word read) clears bit 15 at the clock edge of the strobe. A read with only `csr_be[0]` = 1 leaves bit 15 unchanged.
- R7: When a qualified change and a clearing read land on the same clock edge, bit 15 stays set.
- R8: `dsc_irq` is 1 exactly when bit 15, bit 5 (line-change interrupt enable) and bit 6 (receiver interrupt enable) are all 1.
- R9: A write strobe with `csr_be[0]` = 1 loads bits 7:0 from `csr_wdata[7:0]`. Every low-byte bit reads back as written.
- R10: A write with only `csr_be[1]` = 1 changes nothing. A word write updates only the low byte, and bits 15:8 cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 4 | Raw modem control lines, asynchronous to clk |
| csr_wr | input | 1 | Register write strobe, one cycle per access |
| csr_rd | input | 1 | Register read strobe, one cycle per access |
| csr_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Current register contents (combinational) |
| dsc_irq | output | 1 | Line-change interrupt request |

## Verification
The bench samples the register at each of the three edges that follow a pin change. A design with the wrong synchronizer depth would show the level or the flag one cycle early or late.

The bench forces a change and a word read onto the same edge. A design that gives the clear priority would lose that event.

The bench also checks the byte rules and the enables. A low-byte read must not clear the flag, and a masked line must not set it. A high-byte-only write must not disturb the low byte, and a word write must not reach bit 15. Finally, the bench walks the interrupt enables through each combination and expects a request only with both enables set.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int MDM_LINES    = 4;
  localparam int MDM_CSR_W    = 16;
  localparam int MDM_SYNC_N   = 2;
  localparam int MDM_DSC_BIT  = 15;
  localparam int MDM_LVL_LSB  = 11;
  localparam int MDM_DSIE_BIT = 5;
  localparam int MDM_RXIE_BIT = 6;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = d_async;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] line_en,
  output logic         chg_any
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic [W-1:0] hit;

  always_comb begin
    prev_d = lvl;
    hit    = (lvl ^ prev_q) & line_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign chg_any = |hit;

  // R2: previous-sample register follows the synchronized level one cycle later
  assert_prev_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(lvl)));
endmodule

// File: rtl/mdm_csr.sv
module mdm_csr #(
  parameter int W        = 4,
  parameter int CSR_W    = 16,
  parameter int DSC_BIT  = 15,
  parameter int LVL_LSB  = 11,
  parameter int DSIE_BIT = 5,
  parameter int RXIE_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       be,
  input  logic [CSR_W-1:0] wdata,
  input  logic             chg_any,
  input  logic [W-1:0]     lvl,
  output logic [CSR_W-1:0] rdata,
  output logic [W-1:0]     line_en,
  output logic             irq
);
  localparam int LO_W = CSR_W / 2;

  logic [LO_W-1:0] ctl_q, ctl_d;
  logic            dsc_q, dsc_d;
  logic            clr_rd;
  logic            ld_lo;
  logic            hi_unused;

  assign hi_unused = &{1'b0, wdata[CSR_W-1:LO_W]};

  always_comb begin
    ld_lo  = wr && be[0];
    clr_rd = rd && be[1];
    ctl_d  = ctl_q;
    if (ld_lo) ctl_d = wdata[LO_W-1:0];
    dsc_d = dsc_q;
    if (clr_rd)  dsc_d = 1'b0;
    if (chg_any) dsc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dsc_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      dsc_q <= dsc_d;
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[LO_W-1:0]       = ctl_q;
    rdata[LVL_LSB +: W]   = lvl;
    rdata[DSC_BIT]        = dsc_q;
  end

  assign line_en = ctl_q[W-1:0];
  assign irq     = dsc_q & ctl_q[DSIE_BIT] & ctl_q[RXIE_BIT];

  assert_set_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> dsc_q);
  assert_collision_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_any && rd && be[1]) |=> dsc_q);
  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && be[1] && !chg_any) |=> !dsc_q);
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_q && !(rd && be[1])) |=> dsc_q);
  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsc_q) |-> $past(chg_any));
  assert_hi_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && be[0])) |=> $stable(ctl_q));
endmodule

// File: rtl/mdm_change_csr.sv
module mdm_change_csr
  import mdm_pkg::*;
#(
  parameter int LINES    = MDM_LINES,
  parameter int CSR_W    = MDM_CSR_W,
  parameter int SYNC_N   = MDM_SYNC_N,
  parameter int DSC_BIT  = MDM_DSC_BIT,
  parameter int LVL_LSB  = MDM_LVL_LSB,
  parameter int DSIE_BIT = MDM_DSIE_BIT,
  parameter int RXIE_BIT = MDM_RXIE_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic [1:0]       csr_be,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             dsc_irq
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] line_en;
  logic             chg_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mdm_sync #(.W(LINES), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async (line_in),
    .q_sync  (lvl)
  );

  mdm_edge #(.W(LINES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lvl     (lvl),
    .line_en (line_en),
    .chg_any (chg_any)
  );

  mdm_csr #(
    .W(LINES), .CSR_W(CSR_W), .DSC_BIT(DSC_BIT), .LVL_LSB(LVL_LSB),
    .DSIE_BIT(DSIE_BIT), .RXIE_BIT(RXIE_BIT)
  ) u_csr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (csr_wr),
    .rd      (csr_rd),
    .be      (csr_be),
    .wdata   (csr_wdata),
    .chg_any (chg_any),
    .lvl     (lvl),
    .rdata   (csr_rdata),
    .line_en (line_en),
    .irq     (dsc_irq)
  );

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    dsc_irq |-> (csr_rdata[DSC_BIT] && csr_rdata[DSIE_BIT] && csr_rdata[RXIE_BIT]));
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !csr_rdata[DSC_BIT] |-> !dsc_irq);
endmodule

// File: tb/tb_mdm_change_csr.sv
module tb_mdm_change_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  line_in;
  logic        csr_wr, csr_rd;
  logic [1:0]  csr_be;
  logic [15:0] csr_wdata;
  logic [15:0] csr_rdata;
  logic        dsc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdm_change_csr dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .csr_wr(csr_wr),
    .csr_rd(csr_rd), .csr_be(csr_be), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .dsc_irq(dsc_irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_be = be; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0; csr_be = 2'b00; csr_wdata = '0;
  endtask

  task automatic host_rd(input logic [1:0] be, output logic [15:0] d);
    @(negedge clk); csr_rd = 1'b1; csr_be = be; #1 d = csr_rdata;
    @(negedge clk); csr_rd = 1'b0; csr_be = 2'b00;
  endtask

  task automatic toggle_wait(input int idx);
    @(negedge clk); line_in[idx] = ~line_in[idx];
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset register", csr_rdata, 16'h0000);
    chk("R1 reset irq", {15'd0, dsc_irq}, 16'h0000);
  endtask

  task automatic t_write_rules;
    host_wr(2'b01, 16'h00A5);
    chk("R9 low byte write", csr_rdata, 16'h00A5);
    host_wr(2'b10, 16'h5A5A);
    chk("R10 high-only write ignored", csr_rdata, 16'h00A5);
    host_wr(2'b11, 16'hFF3C);
    chk("R10 word write low only", csr_rdata, 16'h003C);
    host_wr(2'b11, 16'h000F);
    chk("R9 enables loaded", csr_rdata, 16'h000F);
  endtask

  task automatic t_edge_timing;
    logic [15:0] d;
    @(negedge clk); line_in[0] = 1'b1;
    @(negedge clk);
    chk("R2 level not yet after one edge", {15'd0, csr_rdata[11]}, 16'h0000);
    @(negedge clk);
    chk("R2 level after two edges", {15'd0, csr_rdata[11]}, 16'h0001);
    chk("R3 flag not yet after two edges", {15'd0, csr_rdata[15]}, 16'h0000);
    @(negedge clk);
    chk("R3 rising edge sets flag", {15'd0, csr_rdata[15]}, 16'h0001);
    host_rd(2'b11, d);
    chk("R6 word read clears", {15'd0, csr_rdata[15]}, 16'h0000);
    toggle_wait(0);
    chk("R3 falling edge sets flag", {15'd0, csr_rdata[15]}, 16'h0001);
    host_rd(2'b11, d);
  endtask

  task automatic t_mask;
    logic [15:0] d;
    host_wr(2'b01, 16'h000E);
    toggle_wait(0);
    @(negedge clk);
    chk("R4 masked line no flag", {15'd0, csr_rdata[15]}, 16'h0000);
    chk("R4 masked level visible", {15'd0, csr_rdata[11]}, 16'h0001);
    toggle_wait(2);
    chk("R4 enabled line sets flag", {15'd0, csr_rdata[15]}, 16'h0001);
    chk("R2 level bits", {12'd0, csr_rdata[14:11]}, 16'h0005);
    host_rd(2'b10, d);
    host_wr(2'b01, 16'h000F);
  endtask

  task automatic t_sticky_clear;
    logic [15:0] d;
    toggle_wait(1);
    repeat (20) @(negedge clk);
    chk("R5 flag sticky", {15'd0, csr_rdata[15]}, 16'h0001);
    host_rd(2'b01, d);
    chk("R6 low-byte read keeps flag", {15'd0, csr_rdata[15]}, 16'h0001);
    host_rd(2'b10, d);
    chk("R6 high-byte read returned flag", {15'd0, d[15]}, 16'h0001);
    chk("R6 high-byte read clears", {15'd0, csr_rdata[15]}, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] d;
    toggle_wait(3);
    chk("R7 flag set before collision", {15'd0, csr_rdata[15]}, 16'h0001);
    @(negedge clk); line_in[1] = ~line_in[1];
    @(negedge clk);
    @(negedge clk); csr_rd = 1'b1; csr_be = 2'b11;
    @(negedge clk); csr_rd = 1'b0; csr_be = 2'b00;
    chk("R7 change beats clear", {15'd0, csr_rdata[15]}, 16'h0001);
    host_rd(2'b11, d);
    chk("R6 later read clears", {15'd0, csr_rdata[15]}, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    host_wr(2'b01, 16'h002F);
    toggle_wait(0);
    chk("R8 only DS enable no irq", {15'd0, dsc_irq}, 16'h0000);
    host_wr(2'b01, 16'h004F);
    chk("R8 only RX enable no irq", {15'd0, dsc_irq}, 16'h0000);
    host_wr(2'b01, 16'h006F);
    chk("R8 both enables irq", {15'd0, dsc_irq}, 16'h0001);
    host_rd(2'b11, d);
    chk("R8 irq drops on clear", {15'd0, dsc_irq}, 16'h0000);
    host_wr(2'b11, 16'hFFFF);
    chk("R10 word write cannot set bit 15", {15'd0, csr_rdata[15]}, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_in = '0; csr_wr = 1'b0; csr_rd = 1'b0;
    csr_be = 2'b00; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_rules();
    t_edge_timing();
    t_mask();
    t_sticky_clear();
    t_collision();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule